// File: doc/BRIEF.md
# Host Bus Window Decoder and Interrupt Router

This block lets an external host processor treat an embedded microcontroller core as a memory-mapped peripheral. It decodes a 20-bit host address. The upper eight bits must equal an 8-bit base-page strap and a chip-select input must be high. Only then does the block answer, so several copies can sit on one shared bus. A match opens a 4 KB window. The lower part of the window is a shared dual-port RAM that both the host and the core can read and write. The host and the core use it as a mailbox. The host can also use it to load program code for the core.

The two highest bytes of the window are control registers instead of RAM. One holds the core in reset and enables the host interrupt. The other picks which of the host interrupt lines 3 to 15 carries the core's interrupt request. The core comes out of power-on reset held in reset. The host loads code into the RAM and then clears the hold bit so that the core runs that code. All interfaces are single-cycle strobes on one clock. Reads return data one cycle after the read strobe.

Top module: `hostwin_bridge`

## Requirements
- R1: A host access is accepted only when `host_sel` is 1 and `host_addr[19:12]` equals `base_page`. An access that does not match changes no RAM byte and no control register. In the cycle after a host read strobe that did not match, or when no read was strobed, `host_rdata` is 0.
- R2: A matching host write at an offset `host_addr[11:0]` below 0xFFE stores the byte at that RAM offset. A matching host read at such an offset returns the stored byte on `host_rdata` after the next rising clock edge.
- R3: After reset, `core_rst` is 1 and all of `host_irq` are 0. The control register at offset 0xFFE reads 0x01 (bit 0 is hold, bit 1 is interrupt enable). The line-select register at offset 0xFFF reads 0x00 (bits 3:0 are the line number).
- R4: A matching host write to offset 0xFFE sets hold from data bit 0 and enable from data bit 1. `core_rst` equals the new hold value right after that clock edge and changes at no other time.
- R5: The core port reads and writes the same RAM as the host. `core_rdata` shows the byte at `core_addr` one clock edge after it is presented. Bytes written by one side are read back unchanged by the other.
- R6: While `core_rst` is 1, core writes have no effect on the RAM.
- R7: When the host and the core write the same RAM byte on the same clock edge, the host's byte is stored. Writes by the two sides to different bytes on the same edge are both stored.
- R8: With enable 1, hold 0 and a line number n from 3 to 15, `host_irq[n]` is 1 exactly one clock edge after `core_irq_req` is sampled high. All other lines are 0. At most one line is ever high.
- R9: When the line number is 0, 1 or 2, or enable is 0, or hold is 1, every `host_irq` line stays 0 whatever `core_irq_req` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the host and the core side |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_page | input | 8 | Strap value compared with host address bits 19:12 |
| host_sel | input | 1 | Chip select, active high |
| host_addr | input | 20 | Host address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid the cycle after the strobe |
| host_irq | output | 13 | Host interrupt lines, indices 15 down to 3 |
| core_rst | output | 1 | Reset to the embedded core, active high |
| core_addr | input | 12 | Core RAM offset |
| core_we | input | 1 | Core write enable |
| core_wdata | input | 8 | Core write data |
| core_rdata | output | 8 | Core read data, one cycle latency |
| core_irq_req | input | 1 | Interrupt request from the core to the host |

## Verification
The assertions check the following on every cycle:
- The interrupt lines are one-hot or idle.
- A raised line always follows a sampled request while the core was out of reset.
- `core_rst` only moves on the edge of a matching write to the control byte.
- `host_rdata` is zero after any cycle without a matching read.

Only the bench scenarios can show the rest, because it depends on stored data and on which line was selected:
- Mailbox contents as seen from both sides.
- Host priority on a same-byte collision.
- Core writes being dropped during hold.
- Routing to each of the thirteen lines.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
   // number of control bytes overlaid on the top of the window
   localparam int CTRL_REGS = 2;
   localparam int IDX_W     = $clog2(CTRL_REGS);
   localparam int IRQ_NUM_W = 4;

   // register index inside the control block
   localparam int REG_CTRL   = 0;
   localparam int REG_IRQSEL = 1;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_RAM  = 2'd1,
      SRC_REG  = 2'd2
   } rd_src_e;

   typedef struct packed {
      logic [IRQ_NUM_W-1:0] num;
      logic                 en;
      logic                 hold;
   } ctrl_t;
endpackage

// File: rtl/hwb_decode.sv
module hwb_decode
   import hwb_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int OFFS_W = 12
) (
   input  logic [ADDR_W-1:0]        host_addr,
   input  logic                     host_sel,
   input  logic                     host_wr,
   input  logic                     host_rd,
   input  logic [ADDR_W-OFFS_W-1:0] base_page,
   output logic [OFFS_W-1:0]        offs,
   output logic                     ram_we,
   output logic                     ram_re,
   output logic                     reg_we,
   output logic                     reg_re,
   output logic [IDX_W-1:0]         reg_idx
);
   localparam int DEPTH     = 1 << OFFS_W;
   localparam int CTRL_BASE = DEPTH - CTRL_REGS;

   logic hit;
   logic in_regs;

   always_comb begin
      offs    = host_addr[OFFS_W-1:0];
      hit     = host_sel && (host_addr[ADDR_W-1:OFFS_W] == base_page);
      in_regs = (offs >= OFFS_W'(CTRL_BASE));
      ram_we  = hit && host_wr && !in_regs;
      ram_re  = hit && host_rd && !in_regs;
      reg_we  = hit && host_wr && in_regs;
      reg_re  = hit && host_rd && in_regs;
      // control block is aligned, so the low offset bits index it
      reg_idx = offs[IDX_W-1:0];
   end
endmodule

// File: rtl/hwb_ctrl_regs.sv
module hwb_ctrl_regs
   import hwb_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IRQ_LO = 3,
   parameter int IRQ_HI = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [IDX_W-1:0]    idx,
   input  logic [DATA_W-1:0]   wdata,
   input  logic                core_req,
   output logic [DATA_W-1:0]   rdata,
   output logic                core_hold,
   output logic [IRQ_HI:IRQ_LO] irq
);
   ctrl_t                 ctrl_q;
   logic [IRQ_HI:IRQ_LO]  irq_d;
   logic [IRQ_HI:IRQ_LO]  irq_q;
   logic                  route_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q.hold <= 1'b1;
         ctrl_q.en   <= 1'b0;
         ctrl_q.num  <= '0;
      end else if (we) begin
         if (idx == IDX_W'(REG_CTRL)) begin
            ctrl_q.hold <= wdata[0];
            ctrl_q.en   <= wdata[1];
         end else begin
            ctrl_q.num  <= wdata[IRQ_NUM_W-1:0];
         end
      end
   end

   always_comb begin
      if (idx == IDX_W'(REG_CTRL)) rdata = DATA_W'({ctrl_q.en, ctrl_q.hold});
      else                         rdata = DATA_W'(ctrl_q.num);
   end

   assign route_ok = core_req && ctrl_q.en && !ctrl_q.hold;

   for (genvar g = IRQ_LO; g <= IRQ_HI; g++) begin : g_line
      assign irq_d[g] = route_ok && (ctrl_q.num == IRQ_NUM_W'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= '0;
      else        irq_q <= irq_d;
   end

   assign irq       = irq_q;
   assign core_hold = ctrl_q.hold;
endmodule

// File: rtl/hwb_dpram.sv
module hwb_dpram #(
   parameter int DATA_W    = 8,
   parameter int OFFS_W    = 12,
   parameter bit HOST_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              h_we,
   input  logic [OFFS_W-1:0] h_addr,
   input  logic [DATA_W-1:0] h_wdata,
   output logic [DATA_W-1:0] h_rdata,
   input  logic              c_we,
   input  logic [OFFS_W-1:0] c_addr,
   input  logic [DATA_W-1:0] c_wdata,
   output logic [DATA_W-1:0] c_rdata
);
   localparam int DEPTH = 1 << OFFS_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // the later nonblocking write to the same byte is the one kept
   if (HOST_WINS) begin : g_host_first
      always_ff @(posedge clk) begin
         if (c_we) mem[c_addr] <= c_wdata;
         if (h_we) mem[h_addr] <= h_wdata;
      end
   end else begin : g_core_first
      always_ff @(posedge clk) begin
         if (h_we) mem[h_addr] <= h_wdata;
         if (c_we) mem[c_addr] <= c_wdata;
      end
   end

   always_ff @(posedge clk) begin
      h_rdata <= mem[h_addr];
      c_rdata <= mem[c_addr];
   end
endmodule

// File: rtl/hostwin_bridge.sv
module hostwin_bridge
   import hwb_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int OFFS_W    = 12,
   parameter int DATA_W    = 8,
   parameter int IRQ_LO    = 3,
   parameter int IRQ_HI    = 15,
   parameter bit HOST_WINS = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-OFFS_W-1:0] base_page,
   input  logic                     host_sel,
   input  logic [ADDR_W-1:0]        host_addr,
   input  logic                     host_wr,
   input  logic                     host_rd,
   input  logic [DATA_W-1:0]        host_wdata,
   output logic [DATA_W-1:0]        host_rdata,
   output logic [IRQ_HI:IRQ_LO]     host_irq,
   output logic                     core_rst,
   input  logic [OFFS_W-1:0]        core_addr,
   input  logic                     core_we,
   input  logic [DATA_W-1:0]        core_wdata,
   output logic [DATA_W-1:0]        core_rdata,
   input  logic                     core_irq_req
);
   if (ADDR_W <= OFFS_W) begin : g_bad_addr
      $error("hostwin_bridge: ADDR_W must exceed OFFS_W");
   end
   if (OFFS_W < 2 || OFFS_W > 16) begin : g_bad_offs
      $error("hostwin_bridge: OFFS_W out of range");
   end
   if (DATA_W < IRQ_NUM_W) begin : g_bad_data
      $error("hostwin_bridge: DATA_W too narrow for the line number");
   end
   if (IRQ_LO > IRQ_HI || IRQ_HI >= (1 << IRQ_NUM_W)) begin : g_bad_irq
      $error("hostwin_bridge: interrupt line range invalid");
   end

   logic [OFFS_W-1:0] offs;
   logic              ram_we, ram_re, reg_we, reg_re;
   logic [IDX_W-1:0]  reg_idx;
   logic [DATA_W-1:0] ram_rdata, reg_rdata, reg_rdata_q;
   logic              hold;
   rd_src_e           src_q;

   hwb_decode #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) i_decode (
      .host_addr (host_addr),
      .host_sel  (host_sel),
      .host_wr   (host_wr),
      .host_rd   (host_rd),
      .base_page (base_page),
      .offs      (offs),
      .ram_we    (ram_we),
      .ram_re    (ram_re),
      .reg_we    (reg_we),
      .reg_re    (reg_re),
      .reg_idx   (reg_idx)
   );

   hwb_ctrl_regs #(.DATA_W(DATA_W), .IRQ_LO(IRQ_LO), .IRQ_HI(IRQ_HI)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (reg_we),
      .idx       (reg_idx),
      .wdata     (host_wdata),
      .core_req  (core_irq_req),
      .rdata     (reg_rdata),
      .core_hold (hold),
      .irq       (host_irq)
   );

   hwb_dpram #(.DATA_W(DATA_W), .OFFS_W(OFFS_W), .HOST_WINS(HOST_WINS)) i_ram (
      .clk     (clk),
      .h_we    (ram_we),
      .h_addr  (offs),
      .h_wdata (host_wdata),
      .h_rdata (ram_rdata),
      .c_we    (core_we && !hold),
      .c_addr  (core_addr),
      .c_wdata (core_wdata),
      .c_rdata (core_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q       <= SRC_NONE;
         reg_rdata_q <= '0;
      end else begin
         if (ram_re)      src_q <= SRC_RAM;
         else if (reg_re) src_q <= SRC_REG;
         else             src_q <= SRC_NONE;
         if (reg_re) reg_rdata_q <= reg_rdata;
      end
   end

   always_comb begin
      unique case (src_q)
         SRC_RAM: host_rdata = ram_rdata;
         SRC_REG: host_rdata = reg_rdata_q;
         default: host_rdata = '0;
      endcase
   end

   assign core_rst = hold;
endmodule

// File: rtl/hwb_checker.sv
module hwb_checker #(
   parameter int ADDR_W = 20,
   parameter int OFFS_W = 12,
   parameter int DATA_W = 8,
   parameter int IRQ_LO = 3,
   parameter int IRQ_HI = 15
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [ADDR_W-OFFS_W-1:0] base_page,
   input logic                     host_sel,
   input logic [ADDR_W-1:0]        host_addr,
   input logic                     host_wr,
   input logic                     host_rd,
   input logic [DATA_W-1:0]        host_rdata,
   input logic [IRQ_HI:IRQ_LO]     host_irq,
   input logic                     core_rst,
   input logic                     core_irq_req
);
   localparam logic [OFFS_W-1:0] CTRL_OFS = OFFS_W'((1 << OFFS_W) - 2);

   logic hit, ctrl_wr, rd_hit;
   assign hit     = host_sel && (host_addr[ADDR_W-1:OFFS_W] == base_page);
   assign ctrl_wr = hit && host_wr && (host_addr[OFFS_W-1:0] == CTRL_OFS);
   assign rd_hit  = hit && host_rd;

   // R1: no matching read last cycle means a zero data bus
   p_rdata_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_hit) |-> (host_rdata == '0));

   // R4: core reset moves only on a matching control write
   p_hold_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(core_rst) |-> $past(ctrl_wr));

   // R8: never more than one line active
   p_irq_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(host_irq));

   // R8, R9: an active line needs a request while the core was running
   p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|host_irq) |-> ($past(core_irq_req) && !$past(core_rst)));
endmodule

bind hostwin_bridge hwb_checker #(
   .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .DATA_W(DATA_W),
   .IRQ_LO(IRQ_LO), .IRQ_HI(IRQ_HI)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .base_page    (base_page),
   .host_sel     (host_sel),
   .host_addr    (host_addr),
   .host_wr      (host_wr),
   .host_rd      (host_rd),
   .host_rdata   (host_rdata),
   .host_irq     (host_irq),
   .core_rst     (core_rst),
   .core_irq_req (core_irq_req)
);

// File: tb/test_hostwin_bridge.sv
module test_hostwin_bridge;
   localparam int ADDR_W = 20;
   localparam int OFFS_W = 12;
   localparam int DEPTH  = 1 << OFFS_W;
   localparam int CTRL_OFS = DEPTH - 2;
   localparam int SEL_OFS  = DEPTH - 1;
   localparam logic [7:0] PAGE = 8'h5C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic [7:0]  base_page = PAGE;
   logic        host_sel = 1'b0;
   logic [19:0] host_addr = '0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic [15:3] host_irq;
   logic        core_rst;
   logic [11:0] core_addr = '0;
   logic        core_we = 1'b0;
   logic [7:0]  core_wdata = '0;
   logic [7:0]  core_rdata;
   logic        core_irq_req = 1'b0;

   always #2 clk = ~clk;

   hostwin_bridge i_hostwin_bridge (
      .clk(clk), .rst_n(rst_n), .base_page(base_page), .host_sel(host_sel),
      .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
      .core_rst(core_rst), .core_addr(core_addr), .core_we(core_we),
      .core_wdata(core_wdata), .core_rdata(core_rdata),
      .core_irq_req(core_irq_req)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;
   logic [7:0] mem_m [DEPTH];
   bit hold_m = 1'b1;
   bit en_m   = 1'b0;
   logic [3:0] num_m = '0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:3] exp_irq(input bit req);
      logic [15:3] v = '0;
      if (req && en_m && !hold_m && num_m >= 3) v[num_m] = 1'b1;
      return v;
   endfunction

   function automatic logic [19:0] wa(input int off);
      return {PAGE, 12'(off)};
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic h_write(input logic [19:0] a, input logic [7:0] d, input bit sel);
      bit hit = sel && (a[19:12] == PAGE);
      host_addr = a; host_wdata = d; host_sel = sel; host_wr = 1'b1;
      tick();
      host_wr = 1'b0; host_sel = 1'b0;
      if (hit) begin
         if (int'(a[11:0]) == CTRL_OFS) begin hold_m = d[0]; en_m = d[1]; end
         else if (int'(a[11:0]) == SEL_OFS) num_m = d[3:0];
         else mem_m[a[11:0]] = d;
      end
   endtask

   task automatic h_read(input logic [19:0] a, input bit sel, output logic [7:0] d);
      host_addr = a; host_sel = sel; host_rd = 1'b1;
      tick();
      d = host_rdata;
      host_rd = 1'b0; host_sel = 1'b0;
   endtask

   task automatic c_write(input int off, input logic [7:0] d);
      core_addr = 12'(off); core_wdata = d; core_we = 1'b1;
      tick();
      core_we = 1'b0;
      if (!hold_m) mem_m[off] = d;
   endtask

   task automatic c_read(input int off, output logic [7:0] d);
      core_addr = 12'(off);
      tick();
      d = core_rdata;
   endtask

   initial begin
      #600000;
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'h1BAD_5EED));
      #1 rst_n = 1'b0;
      repeat (3) tick();
      // R3: reset state
      chk(core_rst == 1'b1, "R3 core_rst after reset", 32'(core_rst), 1);
      chk(host_irq == '0, "R3 irq after reset", 32'(host_irq), 0);
      chk(host_rdata == '0, "R3 rdata after reset", 32'(host_rdata), 0);
      rst_n = 1'b1;
      tick();
      h_read(wa(CTRL_OFS), 1'b1, d);
      chk(d == 8'h01, "R3 control reg reset", 32'(d), 32'h01);
      h_read(wa(SEL_OFS), 1'b1, d);
      chk(d == 8'h00, "R3 select reg reset", 32'(d), 32'h00);

      // R2: fill the whole RAM from the host side
      for (int i = 0; i < CTRL_OFS; i++) h_write(wa(i), 8'(i) ^ 8'h3C, 1'b1);
      chk(core_rst == 1'b1, "R4 core stays held during download", 32'(core_rst), 1);
      h_read(wa(0), 1'b1, d);
      chk(d == mem_m[0], "R2 read offset 0", 32'(d), 32'(mem_m[0]));
      h_read(wa(CTRL_OFS - 1), 1'b1, d);
      chk(d == mem_m[CTRL_OFS - 1], "R2 read top RAM byte", 32'(d), 32'(mem_m[CTRL_OFS - 1]));

      // R6: core write while held is dropped
      c_write(16, 8'hA5);
      h_read(wa(16), 1'b1, d);
      chk(d == mem_m[16], "R6 core write in hold", 32'(d), 32'(mem_m[16]));

      // R1: unselected and wrong-page accesses
      h_write(wa(20), 8'hEE, 1'b0);
      h_write({PAGE ^ 8'h01, 12'd20}, 8'hDD, 1'b1);
      h_write({PAGE ^ 8'h80, 12'(CTRL_OFS)}, 8'h00, 1'b1);
      chk(core_rst == 1'b1, "R1 miss write to control", 32'(core_rst), 1);
      h_read(wa(20), 1'b1, d);
      chk(d == mem_m[20], "R1 miss writes ignored", 32'(d), 32'(mem_m[20]));
      h_read(wa(20), 1'b0, d);
      chk(d == 8'h00, "R1 unselected read", 32'(d), 0);
      h_read({PAGE ^ 8'h10, 12'd20}, 1'b1, d);
      chk(d == 8'h00, "R1 wrong page read", 32'(d), 0);

      // R4: release the core
      h_write(wa(CTRL_OFS), 8'h00, 1'b1);
      chk(core_rst == 1'b0, "R4 release core", 32'(core_rst), 0);
      h_read(wa(CTRL_OFS), 1'b1, d);
      chk(d == 8'h00, "R4 control readback", 32'(d), 0);

      // R5: mailbox in both directions
      c_write(100, 8'h5A);
      h_read(wa(100), 1'b1, d);
      chk(d == 8'h5A, "R5 core to host", 32'(d), 32'h5A);
      h_write(wa(200), 8'hC3, 1'b1);
      c_read(200, d);
      chk(d == 8'hC3, "R5 host to core", 32'(d), 32'hC3);

      // R7: same-byte collision, then different bytes
      host_addr = wa(300); host_wdata = 8'h11; host_sel = 1'b1; host_wr = 1'b1;
      core_addr = 12'd300; core_wdata = 8'h22; core_we = 1'b1;
      tick();
      host_wr = 1'b0; host_sel = 1'b0; core_we = 1'b0;
      mem_m[300] = 8'h11;
      c_read(300, d);
      chk(d == 8'h11, "R7 host wins collision", 32'(d), 32'h11);
      host_addr = wa(301); host_wdata = 8'h33; host_sel = 1'b1; host_wr = 1'b1;
      core_addr = 12'd302; core_wdata = 8'h44; core_we = 1'b1;
      tick();
      host_wr = 1'b0; host_sel = 1'b0; core_we = 1'b0;
      mem_m[301] = 8'h33; mem_m[302] = 8'h44;
      h_read(wa(301), 1'b1, d);
      chk(d == 8'h33, "R7 host byte beside core", 32'(d), 32'h33);
      h_read(wa(302), 1'b1, d);
      chk(d == 8'h44, "R7 core byte beside host", 32'(d), 32'h44);

      // R8: every valid line
      h_write(wa(CTRL_OFS), 8'h02, 1'b1);
      for (int n = 3; n <= 15; n++) begin
         h_write(wa(SEL_OFS), 8'(n), 1'b1);
         core_irq_req = 1'b1;
         tick();
         chk(host_irq == exp_irq(1'b1), "R8 route line", 32'(host_irq), 32'(exp_irq(1'b1)));
         core_irq_req = 1'b0;
         tick();
         chk(host_irq == '0, "R8 line drops", 32'(host_irq), 0);
      end
      h_read(wa(SEL_OFS), 1'b1, d);
      chk(d == 8'd15, "R8 select readback", 32'(d), 15);

      // R9: lines that stay quiet
      core_irq_req = 1'b1;
      for (int n = 0; n < 3; n++) begin
         h_write(wa(SEL_OFS), 8'(n), 1'b1);
         tick();
         chk(host_irq == '0, "R9 low line number", 32'(host_irq), 0);
      end
      h_write(wa(SEL_OFS), 8'd7, 1'b1);
      h_write(wa(CTRL_OFS), 8'h00, 1'b1);
      tick();
      chk(host_irq == '0, "R9 enable off", 32'(host_irq), 0);
      h_write(wa(CTRL_OFS), 8'h03, 1'b1);
      tick();
      chk(host_irq == '0, "R9 core held", 32'(host_irq), 0);
      chk(core_rst == 1'b1, "R4 hold set again", 32'(core_rst), 1);
      core_irq_req = 1'b0;
      h_write(wa(CTRL_OFS), 8'h00, 1'b1);

      // mixed random traffic against the model
      for (int it = 0; it < 3000; it++) begin
         int op  = int'($urandom % 8);
         int off = int'($urandom % CTRL_OFS);
         logic [7:0] v = 8'($urandom);
         case (op)
            0, 1: h_write(wa(off), v, 1'b1);
            2: begin
               h_read(wa(off), 1'b1, d);
               chk(d == mem_m[off], "R2 random host read", 32'(d), 32'(mem_m[off]));
            end
            3: begin
               logic [7:0] pg = PAGE ^ 8'(1 + $urandom % 255);
               h_write({pg, 12'(off)}, v, v[0]);
               h_read({pg, 12'(off)}, 1'b1, d);
               chk(d == 8'h00, "R1 random miss read", 32'(d), 0);
            end
            4, 5: c_write(off, v);
            6: begin
               c_read(off, d);
               chk(d == mem_m[off], "R5 random core read", 32'(d), 32'(mem_m[off]));
            end
            default: begin
               h_write(wa(CTRL_OFS), {6'd0, v[1], v[0] & v[2]}, 1'b1);
               chk(core_rst == hold_m, "R4 random hold", 32'(core_rst), 32'(hold_m));
            end
         endcase
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule